// File: doc/BRIEF.md
# Memory-Mapped GPIO Port with Edge Capture

This block is a general-purpose parallel I/O port of 1 to 32 pins, reached over a simple word-wide register bus. Software chooses each pin's direction. Output pins drive a stored value. Input pins are brought through a two-flop synchronizer, and their state can be read back.

A detector on the synchronized inputs records events in a sticky per-pin capture register. Software clears that register by writing ones to it. One interrupt line is formed from the mask register combined with either the captured events or, in level mode, the live input levels. The kind of event that counts is fixed by a build-time parameter.

Read responses leave through a two-state response machine. `RD_IDLE` moves to `RD_RESP` when a read strobe is sampled. `RD_RESP` stays in `RD_RESP` on a further strobe and returns to `RD_IDLE` when no strobe is present.

Top module: `gpio_edge_port`

## Requirements
- R1: Reset clears the data, direction, mask and capture registers. After reset every pin is an input (`pin_oe` all zero) and `irq` is low.
- R2: Registers are selected by byte address: 0x0 data, 0x4 direction, 0x8 mask, 0xC capture. An access whose address bits [1:0] are not zero writes nothing and reads zero. The read word is presented on `reg_rdata` with `reg_rvalid` high in the cycle after the read strobe is sampled. `reg_rvalid` is low in any cycle that does not follow a read strobe.
- R3: Writing the direction register takes effect at the sampling clock edge. A bit of 1 sets the matching `pin_oe` bit and makes the pin an output. A bit of 0 makes the pin an input. `pin_out` carries the stored data value on every bit.
- R4: A read of the data register returns, per pin, the stored data bit if the pin is an output. If the pin is an input, it returns the pin level after two synchronizing flops.
- R5: Register bits at or above `PIN_COUNT` always read as zero, and writes to them have no effect.
- R6: The `TRIGGER` parameter selects the event kind: rising (0), falling (1), either edge (2) or level-high (3). In the three edge modes, a qualifying change on a pin sets its capture bit at the third rising clock edge after the change.
- R7: Writing the capture register with a 1 in a bit clears that bit. A 0 in a bit leaves it unchanged.
- R8: If a new event on a pin lands in the same cycle as a clearing write to its capture bit, the bit stays set.
- R9: In edge modes, `irq` is high exactly while some capture bit is set whose mask bit is 1. Mask bits of 0 suppress their pins.
- R10: In level-high mode, `irq` is high while some synchronized input level is 1 with its mask bit set, and the capture register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Byte address of the register access |
| reg_wr_en | input | 1 | Write strobe |
| reg_rd_en | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with `reg_rvalid` |
| reg_rvalid | output | 1 | Read response valid |
| pin_in | input | PIN_COUNT | Pin input levels |
| pin_out | output | PIN_COUNT | Stored output values |
| pin_oe | output | PIN_COUNT | Per-pin output enable |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives one event on a pin in exactly the cycle that a clearing write to that pin's capture bit is sampled. A design that lets the clear win would read the bit back as zero and lose the event.

The same stimulus goes to one instance per trigger mode, so that a falling change is seen to set capture only in the falling and either-edge instances. An instance that mixed up the edge polarity would raise `irq` in the wrong mode.

The interrupt is sampled one cycle before and one cycle after the third clock edge that follows a pin change. This catches a synchronizer that is one stage too short or too long.

Writes with unaligned addresses and writes to bits above the pin count are read back to confirm that nothing changed.

// File: rtl/gpio_pio_pkg.sv
package gpio_pio_pkg;

    localparam int ADDR_W = 4;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        TRIG_RISE  = 2'd0,
        TRIG_FALL  = 2'd1,
        TRIG_BOTH  = 2'd2,
        TRIG_LEVEL = 2'd3
    } trig_e;

    // Word index taken from address bits [3:2]
    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_MASK = 2'd2,
        SEL_CAP  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_RESP = 1'b1
    } rd_state_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] sync_q,
    output logic [W-1:0] prev_q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end
endmodule

// File: rtl/gpio_edge_cap.sv
module gpio_edge_cap
    import gpio_pio_pkg::*;
#(
    parameter int    W       = 8,
    parameter trig_e TRIGGER = TRIG_BOTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_q,
    input  logic [W-1:0] prev_q,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] cap_q
);
    logic [W-1:0] evt;

    generate
        if (TRIGGER == TRIG_RISE) begin : g_rise
            assign evt = sync_q & ~prev_q;
        end else if (TRIGGER == TRIG_FALL) begin : g_fall
            assign evt = ~sync_q & prev_q;
        end else if (TRIGGER == TRIG_BOTH) begin : g_both
            assign evt = sync_q ^ prev_q;
        end else begin : g_level
            logic unused_lvl;
            assign unused_lvl = ^{sync_q, prev_q};
            assign evt = '0;
        end
    endgenerate

    // A new event wins over a clearing write in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= (cap_q & ~clr_mask) | evt;
    end

    // R7: a clear with no competing event empties the bit
    p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_mask & ~evt) != '0) |=> ((cap_q & $past(clr_mask & ~evt)) == '0));

    generate
        if (TRIGGER != TRIG_LEVEL) begin : g_chk
            // R8: every detected event is held, clear or not
            p_keep_evt_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (evt != '0) |=> ((cap_q & $past(evt)) == $past(evt)));
        end
    endgenerate
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
    import gpio_pio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_hit,
    input  reg_sel_e     sel,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] data_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] mask_q,
    output logic [W-1:0] clr_mask
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
            mask_q <= '0;
        end else if (wr_hit) begin
            unique case (sel)
                SEL_DATA: data_q <= wdata;
                SEL_DIR:  dir_q  <= wdata;
                SEL_MASK: mask_q <= wdata;
                SEL_CAP:  ;
            endcase
        end
    end

    assign clr_mask = (wr_hit && sel == SEL_CAP) ? wdata : '0;
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
    import gpio_pio_pkg::*;
#(
    parameter int    PIN_COUNT = 12,
    parameter trig_e TRIGGER   = TRIG_BOTH
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr_en,
    input  logic                 reg_rd_en,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [WORD_W-1:0]    reg_rdata,
    output logic                 reg_rvalid,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] pin_out,
    output logic [PIN_COUNT-1:0] pin_oe,
    output logic                 irq
);
    localparam logic [WORD_W-1:0] PIN_MASK = WORD_W'((64'd1 << PIN_COUNT) - 64'd1);

    logic                 addr_ok, wr_hit;
    reg_sel_e             sel;
    logic [PIN_COUNT-1:0] wr_bits;
    logic [PIN_COUNT-1:0] sync_q, prev_q;
    logic [PIN_COUNT-1:0] data_q, dir_q, mask_q, clr_mask, cap_q;
    logic [WORD_W-1:0]    rd_word, rdata_q;
    rd_state_e            state_q, state_d;

    assign addr_ok = (reg_addr[1:0] == 2'b00);
    assign sel     = reg_sel_e'(reg_addr[3:2]);
    assign wr_hit  = reg_wr_en & addr_ok;
    assign wr_bits = reg_wdata[PIN_COUNT-1:0];

    generate
        if (PIN_COUNT < WORD_W) begin : g_hi
            logic unused_wdata_hi;
            assign unused_wdata_hi = ^reg_wdata[WORD_W-1:PIN_COUNT];
        end
    endgenerate

    gpio_in_sync #(.W(PIN_COUNT)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .sync_q(sync_q), .prev_q(prev_q)
    );

    gpio_ctrl_regs #(.W(PIN_COUNT)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .sel(sel), .wdata(wr_bits),
        .data_q(data_q), .dir_q(dir_q), .mask_q(mask_q), .clr_mask(clr_mask)
    );

    gpio_edge_cap #(.W(PIN_COUNT), .TRIGGER(TRIGGER)) u_cap (
        .clk(clk), .rst_n(rst_n), .sync_q(sync_q), .prev_q(prev_q),
        .clr_mask(clr_mask), .cap_q(cap_q)
    );

    assign pin_out = data_q;
    assign pin_oe  = dir_q;

    generate
        if (TRIGGER == TRIG_LEVEL) begin : g_irq_lvl
            assign irq = |(sync_q & mask_q);
        end else begin : g_irq_edge
            assign irq = |(cap_q & mask_q);
        end
    endgenerate

    // Read word selection
    always_comb begin
        rd_word = '0;
        if (addr_ok) begin
            unique case (sel)
                SEL_DATA: rd_word = WORD_W'((dir_q & data_q) | (~dir_q & sync_q));
                SEL_DIR:  rd_word = WORD_W'(dir_q);
                SEL_MASK: rd_word = WORD_W'(mask_q);
                SEL_CAP:  rd_word = WORD_W'(cap_q);
            endcase
        end
    end

    // Read response machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         rdata_q <= '0;
        else if (reg_rd_en) rdata_q <= rd_word;
    end

    // Read response machine: transitions and outputs
    always_comb begin
        state_d    = state_q;
        reg_rvalid = 1'b0;
        unique case (state_q)
            RD_IDLE: begin
                if (reg_rd_en) state_d = RD_RESP;
            end
            RD_RESP: begin
                reg_rvalid = 1'b1;
                if (!reg_rd_en) state_d = RD_IDLE;
            end
        endcase
    end

    assign reg_rdata = reg_rvalid ? rdata_q : '0;

    p_rvalid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |=> reg_rvalid);
    p_no_stray_rvalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_en |=> !reg_rvalid);
    p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rvalid |-> ((reg_rdata & ~PIN_MASK) == '0));
endmodule

// File: tb/gpio_edge_port_test.sv
module gpio_edge_port_test;
    import gpio_pio_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int PINS = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] reg_addr = '0;
    logic reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [PINS-1:0] pin_in = '0;

    logic [31:0] rd_both, rd_rise, rd_fall, rd_lvl;
    logic rv_both, rv_rise, rv_fall, rv_lvl;
    logic [PINS-1:0] po_both, po_rise, po_fall, po_lvl;
    logic [PINS-1:0] oe_both, oe_rise, oe_fall, oe_lvl;
    logic irq_both, irq_rise, irq_fall, irq_lvl;

    int n_tests = 0;
    int n_fail = 0;
    logic [31:0] exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_edge_port #(.PIN_COUNT(PINS), .TRIGGER(TRIG_BOTH)) uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_rd_en(reg_rd_en), .reg_wdata(reg_wdata), .reg_rdata(rd_both),
        .reg_rvalid(rv_both), .pin_in(pin_in), .pin_out(po_both), .pin_oe(oe_both),
        .irq(irq_both));
    gpio_edge_port #(.PIN_COUNT(PINS), .TRIGGER(TRIG_RISE)) uut_rise (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_rd_en(reg_rd_en), .reg_wdata(reg_wdata), .reg_rdata(rd_rise),
        .reg_rvalid(rv_rise), .pin_in(pin_in), .pin_out(po_rise), .pin_oe(oe_rise),
        .irq(irq_rise));
    gpio_edge_port #(.PIN_COUNT(PINS), .TRIGGER(TRIG_FALL)) uut_fall (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_rd_en(reg_rd_en), .reg_wdata(reg_wdata), .reg_rdata(rd_fall),
        .reg_rvalid(rv_fall), .pin_in(pin_in), .pin_out(po_fall), .pin_oe(oe_fall),
        .irq(irq_fall));
    gpio_edge_port #(.PIN_COUNT(PINS), .TRIGGER(TRIG_LEVEL)) uut_lvl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_rd_en(reg_rd_en), .reg_wdata(reg_wdata), .reg_rdata(rd_lvl),
        .reg_rvalid(rv_lvl), .pin_in(pin_in), .pin_out(po_lvl), .pin_oe(oe_lvl),
        .irq(irq_lvl));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    // Driver: issues a read and pushes the expected word for the both-edge instance
    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        reg_addr = a; reg_rd_en = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        reg_rd_en = 1'b0;
    endtask

    task automatic set_pins(input logic [PINS-1:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (3) @(negedge clk);
    endtask

    // Monitor: pops expected words as responses appear; the level instance must match
    // except that its capture register reads zero (R10)
    always @(negedge clk) begin
        if (rst_n && rv_both) begin
            if (exp_q.size() == 0) begin
                chk("R2 response with no read outstanding", 32'd1, 32'd0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, rd_both, e);
                chk({t, " (R10 level instance)"}, rd_lvl,
                    (reg_addr == 4'hC) ? 32'd0 : e);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pin_oe after reset", 32'(oe_both), 32'd0);
        chk("R1 irq after reset", {28'd0, irq_both, irq_rise, irq_fall, irq_lvl}, 32'd0);
        chk("R2 rvalid idle", 32'(rv_both), 32'd0);
        rd(4'h0, 32'h0, "R1 data after reset");
        rd(4'h4, 32'h0, "R1 dir after reset");
        rd(4'h8, 32'h0, "R1 mask after reset");
        rd(4'hC, 32'h0, "R1 capture after reset");

        // R3 direction, R5 upper bits ignored
        wr(4'h4, 32'hFFFF_F0F0);
        rd(4'h4, 32'h0000_00F0, "R5 dir upper bits dropped");
        chk("R3 pin_oe follows dir", 32'(oe_both), 32'h0F0);
        // R2 unaligned accesses
        wr(4'h5, 32'h0000_0FFF);
        rd(4'h4, 32'h0000_00F0, "R2 unaligned write ignored");
        rd(4'h6, 32'h0, "R2 unaligned read is zero");

        wr(4'h0, 32'hFFFF_FAA5);
        chk("R3 pin_out holds data", 32'(po_both), 32'hAA5);
        set_pins(12'h30C);
        rd(4'h0, 32'h0000_03AC, "R4 mixed data read");
        rd(4'hC, 32'h0000_030C, "R6 capture of rising edges");
        chk("R9 masked irq low", {28'd0, irq_both, irq_rise, irq_fall, irq_lvl}, 32'd0);

        wr(4'h8, 32'hFFFF_F004);
        rd(4'h8, 32'h0000_0004, "R5 mask upper bits dropped");
        chk("R9 irq per mode, mask bit2", {28'd0, irq_both, irq_rise, irq_fall, irq_lvl},
            32'b1101);

        // R7 write-one-to-clear
        wr(4'hC, 32'h008);
        wr(4'hC, 32'h000);
        rd(4'hC, 32'h0000_0304, "R7 clear one bit, zeros keep");
        wr(4'hC, 32'h004);
        chk("R9/R10 irq after clearing masked bit",
            {28'd0, irq_both, irq_rise, irq_fall, irq_lvl}, 32'b0001);

        // R6 falling edges per mode
        set_pins(12'h300);
        rd(4'hC, 32'h0000_030C, "R6 both-edge capture of falls");
        chk("R6/R10 irq after falling edges",
            {28'd0, irq_both, irq_rise, irq_fall, irq_lvl}, 32'b1010);

        wr(4'hC, 32'hFFF);
        rd(4'hC, 32'h0, "R7 clear all");

        // R8 event collides with clear of the same bit
        @(negedge clk); pin_in = 12'h100;
        @(negedge clk);
        @(negedge clk);
        reg_addr = 4'hC; reg_wdata = 32'h200; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
        rd(4'hC, 32'h0000_0200, "R8 event kept over clear");
        wr(4'hC, 32'h200);
        rd(4'hC, 32'h0, "R7 plain clear afterwards");

        // R6 latency: set at third edge after the change
        wr(4'h8, 32'hFFF);
        chk("R9/R10 irq with all masked in",
            {28'd0, irq_both, irq_rise, irq_fall, irq_lvl}, 32'b0001);
        @(negedge clk); pin_in = 12'h101;
        @(negedge clk);
        @(negedge clk);
        chk("R6 no irq before third edge", 32'(irq_both), 32'd0);
        @(negedge clk);
        chk("R6 irq at third edge", {28'd0, irq_both, irq_rise, irq_fall, irq_lvl},
            32'b1101);

        wr(4'h4, 32'h0);
        rd(4'h0, 32'h0000_0101, "R4 all-input data read");

        repeat (3) @(negedge clk);
        chk("R2 all reads answered", 32'(exp_q.size()), 32'd0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule